// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word carried on dual-rail wires: each bit has a "one" wire and a "zero" wire, and a bit holds data once exactly one of them is high. When every rail of every bit is low, the word is in its spacer (empty) state. The block reports three things about the word. It reports when the whole word is complete. It reports when any part of the word still holds data. It also drives a single handshake line with the hysteresis of a multi-input C-element: the line goes high when the last bit arrives and goes low only once the last bit has returned to spacer.

The model is synchronous. A per-bit acknowledge is the OR of the bit's two rails. An AND reduction of the acknowledges gives the complete flag and an OR reduction gives the busy flag. A single two-input C-element, held in a clocked register, combines the two into the handshake. A further flag marks any bit that has both rails high, which is an illegal code; such a bit still counts as acknowledged. All outputs are registered and follow the rails by one clock.

Top module: `dual_rail_completion`

## Requirements
- R1: `word_done` is 1 one cycle after a clock edge at which every bit has at least one rail high, and 0 one cycle after an edge at which some bit has both rails low.
- R2: `word_busy` is 1 one cycle after an edge at which any bit has a rail high, and 0 one cycle after an edge at which all 2N rails are low.
- R3: `handshake` becomes 1 one cycle after an edge at which every bit is acknowledged, whatever its previous value.
- R4: Once `handshake` is 1, it stays 1 while at least one bit still has a rail high, even if `word_done` has dropped.
- R5: `handshake` becomes 0 one cycle after an edge at which all rails are low.
- R6: While `handshake` is 0, a partly filled word (some bits acknowledged but not all) keeps it at 0.
- R7: `code_err` is 1 one cycle after an edge at which any bit has both rails high, and 0 otherwise. A bit with both rails high counts as acknowledged for R1 to R6.
- R8: With `rst` high at a clock edge, all four outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | N | "One" rail of each bit |
| rail_f | input | N | "Zero" rail of each bit |
| word_done | output | 1 | Every bit acknowledged |
| word_busy | output | 1 | Some bit acknowledged |
| handshake | output | 1 | C-element handshake output |
| code_err | output | 1 | Some bit has both rails high |

## Verification
Every output is due exactly one clock after the rail values sampled at an edge. The bench therefore drives the rails on the falling edge and lets its behavioural model update at the rising edge. It compares all four outputs to that model at the next falling edge, so each result is checked one cycle after its stimulus. Scenario checks fill a random word one bit at a time in a random order and then empty it in another random order. They confirm the handshake is still low after the second-to-last bit arrives and high one cycle after the last bit arrives. They also confirm it stays high until one cycle after the last bit clears.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic {RED_AND = 1'b0, RED_OR = 1'b1} red_op_e;
endpackage

// File: rtl/cd_rail_ack.sv
// Per-bit acknowledge and illegal-code detection for a dual-rail word.
module cd_rail_ack #(
  parameter int N = 32
) (
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  output logic [N-1:0] ack,
  output logic [N-1:0] bad
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign ack[i] = rail_t[i] | rail_f[i];
    assign bad[i] = rail_t[i] & rail_f[i];
  end
endmodule

// File: rtl/cd_reduce.sv
// Wide AND or OR reduction, picked by parameter.
module cd_reduce #(
  parameter int W = 32,
  parameter cd_pkg::red_op_e OP = cd_pkg::RED_AND
) (
  input  logic [W-1:0] vec,
  output logic         y
);
  if (OP == cd_pkg::RED_AND) begin : g_and
    assign y = &vec;
  end else begin : g_or
    assign y = |vec;
  end
endmodule

// File: rtl/cd_celement.sv
// Two-input C-element state held in a register: set on done, kept while busy.
module cd_celement (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic keep_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= set_i | (keep_i & q);
  end
endmodule

// File: rtl/dual_rail_completion.sv
module dual_rail_completion #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  output logic         word_done,
  output logic         word_busy,
  output logic         handshake,
  output logic         code_err
);
  logic [N-1:0] ack, bad;
  logic all_c, any_c, err_c;

  cd_rail_ack #(.N(N)) u_ack (
    .rail_t(rail_t), .rail_f(rail_f), .ack(ack), .bad(bad)
  );

  cd_reduce #(.W(N), .OP(cd_pkg::RED_AND)) u_all (.vec(ack), .y(all_c));
  cd_reduce #(.W(N), .OP(cd_pkg::RED_OR))  u_any (.vec(ack), .y(any_c));
  cd_reduce #(.W(N), .OP(cd_pkg::RED_OR))  u_err (.vec(bad), .y(err_c));

  cd_celement u_hold (
    .clk(clk), .rst(rst), .set_i(all_c), .keep_i(any_c), .q(handshake)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_done <= 1'b0;
      word_busy <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      word_done <= all_c;
      word_busy <= any_c;
      code_err  <= err_c;
    end
  end
endmodule

// File: rtl/dual_rail_completion_chk.sv
module dual_rail_completion_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] rail_t,
  input logic [N-1:0] rail_f,
  input logic         word_done,
  input logic         word_busy,
  input logic         handshake,
  input logic         code_err
);
  logic [N-1:0] ackv;
  assign ackv = rail_t | rail_f;

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (rst)
    (&ackv) |=> word_done); // R1
  AST_DONE_FALL: assert property (@(posedge clk) disable iff (rst)
    !(&ackv) |=> !word_done); // R1
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    (|ackv) |=> word_busy); // R2
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    !(|ackv) |=> !word_busy); // R2
  AST_HS_SET: assert property (@(posedge clk) disable iff (rst)
    (&ackv) |=> handshake); // R3
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (handshake && (|ackv)) |=> handshake); // R4
  AST_HS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(|ackv) |=> !handshake); // R5
  AST_HS_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    (!handshake && !(&ackv)) |=> !handshake); // R6
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|(rail_t & rail_f)) |=> code_err); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !(word_done || word_busy || handshake || code_err)); // R8
endmodule

bind dual_rail_completion dual_rail_completion_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
  .word_done(word_done), .word_busy(word_busy),
  .handshake(handshake), .code_err(code_err)
);

// File: tb/dual_rail_completion_test.sv
module dual_rail_completion_test;
  localparam int N = 32;
  localparam int PERIOD = 10;
  localparam int ROUNDS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] rail_t = '0;
  logic [N-1:0] rail_f = '0;
  logic word_done, word_busy, handshake, code_err;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_rail_completion #(.N(N)) uut (
    .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
    .word_done(word_done), .word_busy(word_busy),
    .handshake(handshake), .code_err(code_err)
  );

  // Behavioural reference: counts acknowledged bits each edge.
  bit e_done = 0, e_busy = 0, e_hs = 0, e_err = 0;
  always @(posedge clk) begin
    int cnt;
    bit both;
    cnt = 0;
    both = 0;
    for (int i = 0; i < N; i++) begin
      if (rail_t[i] || rail_f[i]) cnt++;
      if (rail_t[i] && rail_f[i]) both = 1;
    end
    if (rst) begin
      e_done <= 0; e_busy <= 0; e_hs <= 0; e_err <= 0;
    end else begin
      e_done <= (cnt == N);
      e_busy <= (cnt > 0);
      e_hs   <= (cnt == N) || ((cnt > 0) && e_hs);
      e_err  <= both;
    end
  end

  task automatic check(input logic act, input bit exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        check(word_done, 1'b0, "R8 done in reset");
        check(word_busy, 1'b0, "R8 busy in reset");
        check(handshake, 1'b0, "R8 handshake in reset");
        check(code_err,  1'b0, "R8 err in reset");
      end else begin
        check(word_done, e_done, "R1 word_done");
        check(word_busy, e_busy, "R2 word_busy");
        check(handshake, e_hs,   "R3/R4/R5 handshake");
        check(code_err,  e_err,  "R7 code_err");
      end
    end
  end

  task automatic shuffle(ref int ord[N]);
    for (int i = 0; i < N; i++) ord[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j;
      int tmp;
      j = int'($urandom_range(i, 0));
      tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
    end
  endtask

  task automatic one_round(input bit inject_bad);
    int ord[N];
    logic [N-1:0] val;
    val = N'($urandom());
    shuffle(ord);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (inject_bad && k == N / 2) begin
        rail_t[ord[k]] = 1'b1; rail_f[ord[k]] = 1'b1;
      end else begin
        rail_t[ord[k]] = val[ord[k]]; rail_f[ord[k]] = ~val[ord[k]];
      end
      if (k == N - 2) begin
        @(negedge clk);
        check(handshake, 1'b0, "R6 no rise before last bit");
        #1;
      end
    end
    @(negedge clk);
    check(handshake, 1'b1, "R3 rise after last bit");
    if (inject_bad) check(code_err, 1'b1, "R7 illegal bit flagged and acknowledged");
    shuffle(ord);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      rail_t[ord[k]] = 1'b0; rail_f[ord[k]] = 1'b0;
      if (k == N - 2) begin
        @(negedge clk);
        check(handshake, 1'b1, "R4 hold until last bit clears");
        check(word_done, 1'b0, "R1 done dropped on partial clear");
        #1;
      end
    end
    @(negedge clk);
    check(handshake, 1'b0, "R5 fall after last bit clears");
    check(word_busy, 1'b0, "R2 busy low at spacer");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rail_t = '1;  // driven during reset: must have no effect
    @(negedge clk);
    check(handshake, 1'b0, "R8 reset dominates full word");
    rail_t = '0;
    rst = 1'b0;
    for (int r = 0; r < ROUNDS; r++) one_round(r % 4 == 3);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule